// File: doc/BRIEF.md
# Serial Byte Ingest Port

This block is the receive side of a three-wire synchronous serial link driven by an external host. The host supplies a bit clock, a framing strobe and a data line. The block samples all three on the system clock through synchroniser chains and finds their edges internally. It assembles the data bits into bytes, most significant bit first.

A rising edge on the framing strobe sets the byte boundary: the next rising bit-clock edge carries bit 7 of a new byte. Framing then continues every eight bit-clock edges until the strobe rises again. Finished bytes enter a 256-entry byte queue. On-chip logic drains the queue through a valid/ready port, which also reports how many bytes the queue holds.

An active-low request line tells the host to send more data whenever the queue runs low. This lets the host refill it in bursts.

Top module: `serial_byte_ingest`

## Requirements
- R1: After reset the queue is empty: fill count 0, `rd_valid_o` low, `req_n_o` low and `ovf_o` low.
- R2: `ser_dat_i` is sampled on the rising edge of `ser_sck_i`. The first bit of a byte is bit 7, and bit 0 comes last.
- R3: Bit-clock edges that arrive after reset and before the first rising edge of `ser_frm_i` assemble nothing.
- R4: A rising edge of `ser_frm_i` throws away any partly assembled byte. The next rising bit-clock edge carries bit 7.
- R5: After one framing edge, bytes follow back to back, one byte for every eight rising bit-clock edges, with no further strobe.
- R6: The queue is first-in first-out. While `rd_valid_o` is high, `rd_data_o` holds the oldest byte. A byte is removed on a clock edge where `rd_valid_o` and `rd_ready_i` are both high.
- R7: `fill_o` equals the number of bytes held. A write alone raises it by one, and a read alone lowers it by one.
- R8: `req_n_o` is low exactly when `fill_o` is below REQ_LEVEL (default 64), and high otherwise.
- R9: A byte that completes while the queue holds DEPTH (default 256) bytes is dropped and leaves the contents unchanged. It sets `ovf_o`, which stays high until reset.
- R10: A completed byte shows on `fill_o` four system clock edges after the rising bit-clock edge that carried its bit 0 reaches the pin, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sck_i | input | 1 | Host bit clock, asynchronous |
| ser_frm_i | input | 1 | Host framing strobe; a rising edge aligns the next byte |
| ser_dat_i | input | 1 | Host serial data, changed by the host while the bit clock is low |
| req_n_o | output | 1 | Active-low request for more data |
| rd_valid_o | output | 1 | Queue holds at least one byte |
| rd_data_o | output | 8 | Oldest queued byte |
| rd_ready_i | input | 1 | Drain side accepts the byte at the next clock edge |
| fill_o | output | 9 | Number of bytes in the queue |
| ovf_o | output | 1 | Sticky flag: a byte was dropped because the queue was full |

## Verification
A pin edge passes two synchroniser stages and the byte register before the queue write. The count therefore moves on the fourth system clock edge after the final bit-clock rise, and the request line moves in that same cycle. The bench drives every pin on a falling system clock edge. For the latency requirement it samples the count exactly three and four falling edges after the last bit-clock rise. All other checks wait six cycles past the last bit, so they never sample a value that is still moving. Reads are sampled on the falling edge before the edge that takes the byte, and the count is checked on the following falling edge.

// File: rtl/sbi_pkg.sv
package sbi_pkg;

   // one sampled snapshot of the three host pins
   typedef struct packed {
      logic sck;
      logic frm;
      logic dat;
   } sbi_pins_t;

   localparam int unsigned SBI_BYTE_W = 8;

endpackage

// File: rtl/sbi_sync.sv
module sbi_sync
   import sbi_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  sbi_pins_t pins_i,
   output sbi_pins_t pins_o,
   output logic      sck_rise_o,
   output logic      frm_rise_o
);

   initial assert (STAGES >= 2) else $error("sbi_sync: STAGES must be at least 2");

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      sbi_pins_t q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= pins_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_stage[g-1].q;
         end
      end
   end

   sbi_pins_t prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= g_stage[STAGES-1].q;
   end

   assign pins_o     = g_stage[STAGES-1].q;
   assign sck_rise_o = g_stage[STAGES-1].q.sck & ~prev_q.sck;
   assign frm_rise_o = g_stage[STAGES-1].q.frm & ~prev_q.frm;

endmodule

// File: rtl/sbi_framer.sv
module sbi_framer
   import sbi_pkg::*;
#(
   parameter int unsigned W = SBI_BYTE_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck_rise_i,
   input  logic         frm_rise_i,
   input  logic         dat_i,
   output logic         byte_valid_o,
   output logic [W-1:0] byte_o
);

   localparam int unsigned BW = (W > 1) ? $clog2(W) : 1;
   localparam logic [BW-1:0] TOP_BIT = BW'(W - 1);

   logic          aligned_q;
   logic [BW-1:0] bit_cnt_q;
   logic [W-1:0]  shift_q;
   logic [W-1:0]  shift_nxt;

   assign shift_nxt = {shift_q[W-2:0], dat_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned_q    <= 1'b0;
         bit_cnt_q    <= TOP_BIT;
         shift_q      <= '0;
         byte_valid_o <= 1'b0;
         byte_o       <= '0;
      end else begin
         byte_valid_o <= 1'b0;
         if (frm_rise_i) begin
            aligned_q <= 1'b1;
            bit_cnt_q <= TOP_BIT;
         end else if (sck_rise_i && aligned_q) begin
            shift_q <= shift_nxt;
            if (bit_cnt_q == '0) begin
               byte_valid_o <= 1'b1;
               byte_o       <= shift_nxt;
               bit_cnt_q    <= TOP_BIT;
            end else begin
               bit_cnt_q <= bit_cnt_q - 1'b1;
            end
         end
      end
   end

   assert_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_rise_i |=> (aligned_q && bit_cnt_q == TOP_BIT && !byte_valid_o));

   assert_no_byte_unaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned_q |=> !byte_valid_o);

endmodule

// File: rtl/sbi_fifo.sv
module sbi_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push_i,
   input  logic [W-1:0]                 push_data_i,
   input  logic                         rd_ready_i,
   output logic                         rd_valid_o,
   output logic [W-1:0]                 rd_data_o,
   output logic [$clog2(DEPTH+1)-1:0]   count_o,
   output logic                         ovf_o
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = $clog2(DEPTH + 1);

   initial assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
      else $error("sbi_fifo: DEPTH must be a power of two");

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          full, do_push, do_pop;

   assign full       = (cnt_q == CW'(DEPTH));
   assign rd_valid_o = (cnt_q != '0);
   assign do_push    = push_i && !full;
   assign do_pop     = rd_valid_o && rd_ready_i;
   assign rd_data_o  = mem_q[rp_q];
   assign count_o    = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= push_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
         if (push_i && full) ovf_o <= 1'b1;
      end
   end

   assert_fill_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !full && !rd_ready_i) |=> (count_o == $past(count_o) + 1'b1));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full && !rd_ready_i) |=> ($stable(count_o) && ovf_o));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);

   assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_valid_o && !push_i) |=> !rd_valid_o);

endmodule

// File: rtl/serial_byte_ingest.sv
module serial_byte_ingest
   import sbi_pkg::*;
#(
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned REQ_LEVEL   = 64,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_sck_i,
   input  logic                  ser_frm_i,
   input  logic                  ser_dat_i,
   output logic                  req_n_o,
   output logic                  rd_valid_o,
   output logic [SBI_BYTE_W-1:0] rd_data_o,
   input  logic                  rd_ready_i,
   output logic [CW-1:0]         fill_o,
   output logic                  ovf_o
);

   initial assert (REQ_LEVEL >= 1 && REQ_LEVEL <= DEPTH)
      else $error("serial_byte_ingest: REQ_LEVEL out of range");

   sbi_pins_t             pins_raw, pins_s;
   logic                  sck_rise, frm_rise;
   logic                  byte_push;
   logic [SBI_BYTE_W-1:0] byte_data;

   assign pins_raw = '{sck: ser_sck_i, frm: ser_frm_i, dat: ser_dat_i};

   sbi_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .pins_i     (pins_raw),
      .pins_o     (pins_s),
      .sck_rise_o (sck_rise),
      .frm_rise_o (frm_rise)
   );

   sbi_framer #(.W(SBI_BYTE_W)) u_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .sck_rise_i   (sck_rise),
      .frm_rise_i   (frm_rise),
      .dat_i        (pins_s.dat),
      .byte_valid_o (byte_push),
      .byte_o       (byte_data)
   );

   sbi_fifo #(.W(SBI_BYTE_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (byte_push),
      .push_data_i (byte_data),
      .rd_ready_i  (rd_ready_i),
      .rd_valid_o  (rd_valid_o),
      .rd_data_o   (rd_data_o),
      .count_o     (fill_o),
      .ovf_o       (ovf_o)
   );

   assign req_n_o = (fill_o >= CW'(REQ_LEVEL));

   assert_req_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n_o) |-> $past(byte_push));

   assert_req_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n_o) |-> $past(rd_valid_o && rd_ready_i));

endmodule

// File: tb/serial_byte_ingest_tb.sv
module serial_byte_ingest_tb;

   logic       clk = 1'b0;
   logic       rst_n, sck, frm, dat, rd_ready;
   logic       req_n, rd_valid, ovf;
   logic [7:0] rd_data;
   logic [8:0] fill;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   localparam logic [7:0] VEC [8] = '{8'hA5, 8'h3C, 8'h00, 8'hFF,
                                      8'h81, 8'h7E, 8'h12, 8'hC9};

   always #5 clk = ~clk;

   serial_byte_ingest u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ser_sck_i  (sck),
      .ser_frm_i  (frm),
      .ser_dat_i  (dat),
      .req_n_o    (req_n),
      .rd_valid_o (rd_valid),
      .rd_data_o  (rd_data),
      .rd_ready_i (rd_ready),
      .fill_o     (fill),
      .ovf_o      (ovf)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      dat = b;
      idle(4);
      sck = 1'b1;
      idle(4);
      sck = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic send_sync();
      frm = 1'b1;
      idle(4);
      frm = 1'b0;
      idle(4);
   endtask

   task automatic pop(output logic [7:0] v);
      v = rd_data;
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] got;
      rst_n = 1'b0; sck = 1'b0; frm = 1'b0; dat = 1'b0; rd_ready = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 reset state
      chk("R1 fill", fill, 0);
      chk("R1 valid", rd_valid, 0);
      chk("R1 req_n", req_n, 0);
      chk("R1 ovf", ovf, 0);

      // R3 no framing edge yet: bits ignored
      send_byte(8'hFF);
      idle(6);
      chk("R3 fill", fill, 0);
      chk("R3 valid", rd_valid, 0);

      // R10 latency, R2 bit order
      send_sync();
      for (int i = 7; i >= 1; i--) send_bit(8'h5A >> i);
      dat = 1'b0;
      idle(4);
      sck = 1'b1;
      idle(3);
      chk("R10 early", fill, 0);
      idle(1);
      chk("R10 due", fill, 1);
      idle(3);
      sck = 1'b0;
      idle(2);
      pop(got);
      chk("R2 msb first", got, 8'h5A);

      // table walk: R5 back-to-back, R6 order, R7 count
      send_sync();
      for (int k = 0; k < 8; k++) send_byte(VEC[k]);
      idle(6);
      chk("R7 fill", fill, 8);
      chk("R8 req_n low", req_n, 0);
      for (int k = 0; k < 8; k++) begin
         chk("R6 valid", rd_valid, 1);
         pop(got);
         chk("R5 R6 data", got, VEC[k]);
         chk("R7 fill down", fill, 7 - k);
      end
      chk("R6 empty", rd_valid, 0);

      // R4 realign mid-byte
      send_sync();
      for (int i = 0; i < 5; i++) send_bit(1'b1);
      send_sync();
      send_byte(8'h0F);
      idle(6);
      chk("R4 fill", fill, 1);
      pop(got);
      chk("R4 data", got, 8'h0F);

      // R8 threshold, R9 full drop
      send_sync();
      for (int i = 0; i < 256; i++) begin
         send_byte(i[7:0]);
         if (i == 62) begin idle(6); chk("R8 at 63", req_n, 0); end
         if (i == 63) begin idle(6); chk("R8 at 64", req_n, 1); end
      end
      idle(6);
      chk("R9 fill full", fill, 256);
      chk("R9 ovf before", ovf, 0);
      send_byte(8'hEE);
      idle(6);
      chk("R9 fill kept", fill, 256);
      chk("R9 ovf set", ovf, 1);
      for (int i = 0; i < 256; i++) begin
         pop(got);
         chk("R9 contents", got, i);
         if (i == 191) chk("R8 at 64 drain", req_n, 1);
         if (i == 192) chk("R8 at 63 drain", req_n, 0);
      end
      chk("R7 drained", fill, 0);
      chk("R9 ovf sticky", ovf, 1);

      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(2);
      chk("R1 ovf cleared", ovf, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule